// File: doc/BRIEF.md
# Keyed Watchdog Timer with Interrupt-or-Reset Timeout

This block is a software watchdog. It counts ticks of a slow oscillator, given to it as a one-cycle enable in the system clock domain. Software must restart the count before a fixed number of ticks has passed. If it does not, the block raises one of two outputs. The first is a one-cycle non-maskable interrupt request. The second is a system reset request held for a few cycles. A mode bit chooses which one is raised.

Software reaches the block through two byte-wide registers. The strobes are a plain write strobe and a combinational read. The control register holds a 4-bit run/stop key and a restart bit that clears itself. The status register holds a sticky interrupt-timeout flag and the mode bit.

Only one exact key value stops the counter, and every other value lets it run. Stopping holds the count without clearing it. An oscillator-gate input models sleep: while the gate is low the count freezes. In halt the gate stays high, so the count keeps advancing.

Top module: `keyed_wdog`

## Requirements
- R1: After reset, the control register reads 0x0A (key field 4'b1010, so the counter is stopped). The status register reads 0x00. Both timeout outputs are low.
- R2: The control register is at address 0, and its bits [3:0] are the run/stop key. Writing exactly 4'b1010 stops counting. Any other key value lets the count advance on every oscillator tick. While stopped, the count is held, not cleared.
- R3: Writing 1 to control bit 4 clears the count, so a full new period begins. Bit 4 always reads back 0. A single write can carry both the restart and a run key.
- R4: A timeout occurs on the TIMEOUT_TICKS-th counted tick after a restart. The count then wraps to zero, and the next timeout follows after another TIMEOUT_TICKS counted ticks.
- R5: A counter that is stopped and later re-enabled without a restart resumes from its held value. It times out after only the ticks that remained.
- R6: The status register is at address 1, and bit 1 is the mode. When the mode is 0, a timeout gives a one-cycle pulse on nmi_req and sets status bit 0.
- R7: Status bit 0 stays set until a restart write clears it. Writes to status bit 0 have no effect.
- R8: When the mode is 1, a timeout holds sys_rst_req high for exactly RST_HOLD clock cycles. It does not pulse nmi_req and does not set status bit 0.
- R9: While osc_run is low (sleep), ticks do not advance the count. With osc_run high (run or halt), they do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_tick | input | 1 | One-cycle enable per slow-oscillator period |
| osc_run | input | 1 | High while the oscillator runs; low models sleep |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Write address: 0 control, 1 status |
| bus_wdata | input | 8 | Write data |
| rd_addr | input | 1 | Read address: 0 control, 1 status |
| rd_data | output | 8 | Read data for rd_addr |
| nmi_req | output | 1 | One-cycle interrupt timeout pulse |
| sys_rst_req | output | 1 | Stretched reset timeout request |

## Verification
The count itself is hidden. The hardest case to reach from the ports is a resumed count: a stop that held a partial count, followed by a run write with no restart. The bench sweeps every possible held count for a small period. It restarts, gives k ticks, stops, and sends extra ticks that must have no effect. It then re-enables the counter and measures the ticks left until the interrupt, which must be the period minus k. The same approach of counting ticks to the timeout is used to show that sleep gating and a mid-period restart work.

// File: rtl/wd_pkg.sv
// Package: shared constants for the keyed watchdog.
// Assumes a byte-wide register path and two register addresses.
package wd_pkg;
    localparam int DATA_W  = 8;
    localparam int KEY_W   = 4;
    localparam logic [KEY_W-1:0] STOP_KEY = 4'b1010;

    // Bit positions decoded by software.
    localparam int CTL_RESTART_BIT = 4;
    localparam int STAT_FLAG_BIT   = 0;
    localparam int STAT_MODE_BIT   = 1;

    typedef enum logic {
        REG_CTL  = 1'b0,
        REG_STAT = 1'b1
    } wd_reg_e;

    typedef enum logic {
        ACT_NMI   = 1'b0,
        ACT_RESET = 1'b1
    } wd_action_e;
endpackage

// File: rtl/wd_regs.sv
// Module: wd_regs
// The register file for the watchdog: a run/stop key, a self-clearing
// restart strobe, the mode bit and a sticky interrupt-timeout flag.
// Assumes that writes are single-cycle strobes and that reads are free of side effects.
module wd_regs
    import wd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              rd_addr,
    input  logic              expire,
    output logic [DATA_W-1:0] rd_data,
    output logic              restart,
    output logic              run,
    output wd_action_e        mode,
    output logic              nmi_flag
);
    logic [KEY_W-1:0] key_q;
    logic             ctl_wr;
    logic             stat_wr;
    logic             unused_wbits;

    assign ctl_wr  = bus_wr && (wd_reg_e'(bus_addr) == REG_CTL);
    assign stat_wr = bus_wr && (wd_reg_e'(bus_addr) == REG_STAT);
    assign restart = ctl_wr && bus_wdata[CTL_RESTART_BIT];
    assign run     = (key_q != STOP_KEY);
    assign unused_wbits = ^{bus_wdata[DATA_W-1:CTL_RESTART_BIT+1]};

    // Purpose: hold the run/stop key, which starts as the stop value.
    always_ff @(posedge clk) begin
        if (!rst_n)      key_q <= STOP_KEY;
        else if (ctl_wr) key_q <= bus_wdata[KEY_W-1:0];
    end

    // Purpose: hold the timeout action chosen by software.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode <= ACT_NMI;
        else if (stat_wr) mode <= wd_action_e'(bus_wdata[STAT_MODE_BIT]);
    end

    // Purpose: sticky flag, set by an interrupt timeout and cleared only by a restart.
    always_ff @(posedge clk) begin
        if (!rst_n)                           nmi_flag <= 1'b0;
        else if (restart)                     nmi_flag <= 1'b0;
        else if (expire && mode == ACT_NMI)   nmi_flag <= 1'b1;
    end

    // Purpose: read multiplexer; the restart bit always reads as zero.
    always_comb begin
        rd_data = '0;
        if (wd_reg_e'(rd_addr) == REG_CTL) begin
            rd_data[KEY_W-1:0] = key_q;
        end else begin
            rd_data[STAT_FLAG_BIT] = nmi_flag;
            rd_data[STAT_MODE_BIT] = (mode == ACT_RESET);
        end
    end
endmodule

// File: rtl/wd_period_counter.sv
// Module: wd_period_counter
// Counts oscillator ticks while enabled and signals the last tick of each
// period. A restart clears the count and suppresses that cycle's timeout.
// Assumes TIMEOUT_TICKS >= 2.
module wd_period_counter #(
    parameter int unsigned TIMEOUT_TICKS = 131072,
    localparam int CNT_W = $clog2(TIMEOUT_TICKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic             osc_tick,
    input  logic             osc_run,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_TICKS - 1);

    logic advance;
    logic at_last;

    assign advance = run && osc_tick && osc_run;
    assign at_last = (count == LAST);
    assign expire  = advance && at_last && !restart;

    // Purpose: advance, hold or clear the period count.
    always_ff @(posedge clk) begin
        if (!rst_n)       count <= '0;
        else if (restart) count <= '0;
        else if (advance) count <= at_last ? '0 : count + 1'b1;
    end
endmodule

// File: rtl/wd_action.sv
// Module: wd_action
// Turns a timeout into its output: a one-cycle interrupt pulse, or a
// reset request stretched to RST_HOLD cycles. Assumes RST_HOLD >= 1.
module wd_action
    import wd_pkg::*;
#(
    parameter int unsigned RST_HOLD = 4,
    localparam int HOLD_W = $clog2(RST_HOLD + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       expire,
    input  wd_action_e mode,
    output logic       nmi_req,
    output logic       sys_rst_req
);
    logic [HOLD_W-1:0] hold_q;

    // Purpose: register the interrupt pulse for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) nmi_req <= 1'b0;
        else        nmi_req <= expire && (mode == ACT_NMI);
    end

    // Purpose: load and count down the reset stretch.
    always_ff @(posedge clk) begin
        if (!rst_n)                             hold_q <= '0;
        else if (expire && mode == ACT_RESET)   hold_q <= HOLD_W'(RST_HOLD);
        else if (hold_q != '0)                  hold_q <= hold_q - 1'b1;
    end

    assign sys_rst_req = (hold_q != '0);
endmodule

// File: rtl/keyed_wdog.sv
// Module: keyed_wdog
// Top of the keyed watchdog. It connects the register file, the period counter
// and the timeout action stage. Assumes that osc_tick is synchronous to clk.
module keyed_wdog
    import wd_pkg::*;
#(
    parameter int unsigned TIMEOUT_TICKS = 131072,
    parameter int unsigned RST_HOLD      = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        osc_tick,
    input  logic        osc_run,
    input  logic        bus_wr,
    input  logic        bus_addr,
    input  logic [7:0]  bus_wdata,
    input  logic        rd_addr,
    output logic [7:0]  rd_data,
    output logic        nmi_req,
    output logic        sys_rst_req
);
    localparam int CNT_W = $clog2(TIMEOUT_TICKS);

    logic             restart;
    logic             run;
    logic             expire;
    logic             nmi_flag;
    wd_action_e       mode;
    logic [CNT_W-1:0] period_count;

    wd_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .rd_addr   (rd_addr),
        .expire    (expire),
        .rd_data   (rd_data),
        .restart   (restart),
        .run       (run),
        .mode      (mode),
        .nmi_flag  (nmi_flag)
    );

    wd_period_counter #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .run      (run),
        .osc_tick (osc_tick),
        .osc_run  (osc_run),
        .count    (period_count),
        .expire   (expire)
    );

    wd_action #(.RST_HOLD(RST_HOLD)) u_act (
        .clk         (clk),
        .rst_n       (rst_n),
        .expire      (expire),
        .mode        (mode),
        .nmi_req     (nmi_req),
        .sys_rst_req (sys_rst_req)
    );
endmodule

// File: rtl/wd_checker.sv
// Module: wd_checker
// Property checks for keyed_wdog, attached to it by the bind below.
module wd_checker #(
    parameter int unsigned TIMEOUT_TICKS = 131072,
    parameter int unsigned RST_HOLD      = 4,
    parameter int CNT_W = 17
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] count,
    input logic             restart,
    input logic             run,
    input logic             osc_run,
    input logic             osc_tick,
    input logic             nmi_req,
    input logic             sys_rst_req,
    input logic             nmi_flag
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_TICKS - 1);
    logic [31:0] rst_len;

    // Purpose: count how many consecutive cycles the reset request has been high.
    always_ff @(posedge clk) begin
        if (!rst_n)           rst_len <= '0;
        else if (sys_rst_req) rst_len <= rst_len + 1;
        else                  rst_len <= '0;
    end

    a_r2_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !restart) |=> $stable(count));
    a_r9_sleep_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_run && !restart) |=> $stable(count));
    a_r3_restart_clear: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (count == '0 && !nmi_flag));
    a_r4_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (run && osc_run && osc_tick && !restart && count != LAST)
        |=> count == CNT_W'($past(count) + 1'b1));
    a_r4_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= LAST);
    a_r6_flag_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |-> nmi_flag);
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |=> !nmi_req);
    a_r8_rst_max: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |-> rst_len < RST_HOLD);
    a_r8_rst_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst_req) |-> rst_len == RST_HOLD);
endmodule

bind keyed_wdog wd_checker #(
    .TIMEOUT_TICKS(TIMEOUT_TICKS),
    .RST_HOLD(RST_HOLD),
    .CNT_W(CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .count       (period_count),
    .restart     (restart),
    .run         (run),
    .osc_run     (osc_run),
    .osc_tick    (osc_tick),
    .nmi_req     (nmi_req),
    .sys_rst_req (sys_rst_req),
    .nmi_flag    (nmi_flag)
);

// File: tb/sim_keyed_wdog.sv
module sim_keyed_wdog;
    localparam int CLK_PERIOD = 10;
    localparam int TMO  = 8;
    localparam int HOLD = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_tick = 1'b0;
    logic       osc_run = 1'b1;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic       rd_addr = 1'b0;
    logic [7:0] rd_data;
    logic       nmi_req;
    logic       sys_rst_req;

    int n_chk = 0;
    int n_fail = 0;

    keyed_wdog #(.TIMEOUT_TICKS(TMO), .RST_HOLD(HOLD)) u0 (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .osc_run(osc_run),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .nmi_req(nmi_req), .sys_rst_req(sys_rst_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output int d);
        rd_addr = a;
        #1;
        d = int'(rd_data);
    endtask

    task automatic tick(output logic nmi, output logic rst);
        @(negedge clk);
        osc_tick = 1'b1;
        @(negedge clk);
        osc_tick = 1'b0;
        nmi = nmi_req;
        rst = sys_rst_req;
    endtask

    // Ticks until an interrupt pulse; returns the tick index (0 if none).
    task automatic ticks_to_nmi(input int max, output int n);
        logic nm, rs;
        n = 0;
        for (int i = 1; i <= max; i++) begin
            tick(nm, rs);
            if (nm && n == 0) n = i;
            if (n != 0) break;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int v;
        int n;
        int hc;
        logic nm, rs;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(1'b0, v); chk("R1 ctl", v, 8'h0A);
        rd(1'b1, v); chk("R1 stat", v, 8'h00);
        chk("R1 nmi", int'(nmi_req), 0);
        chk("R1 rst", int'(sys_rst_req), 0);

        // R2 stopped from reset: no timeout
        ticks_to_nmi(20, n); chk("R2 stopped after reset", n, 0);

        // R3 restart with run in one write, restart bit reads 0
        wr(1'b0, 8'h1F);
        rd(1'b0, v); chk("R3 ctl readback", v, 8'h0F);

        // R4/R6 first timeout, flag, single pulse
        ticks_to_nmi(20, n); chk("R4 period", n, TMO);
        rd(1'b1, v); chk("R6 flag set", v, 8'h01);
        @(negedge clk); chk("R6 pulse one cycle", int'(nmi_req), 0);
        ticks_to_nmi(20, n); chk("R4 wrap period", n, TMO);

        // R7 sticky flag, bit0 write ignored, cleared by restart
        wr(1'b1, 8'h00);
        rd(1'b1, v); chk("R7 flag kept", v, 8'h01);
        wr(1'b0, 8'h13);
        rd(1'b1, v); chk("R7 restart clears flag", v, 8'h00);
        wr(1'b1, 8'h01);
        rd(1'b1, v); chk("R7 bit0 write ignored", v, 8'h00);

        // R2 every key value: only 4'b1010 stops
        for (int k = 0; k < 16; k++) begin
            wr(1'b0, 8'(8'h10 | k));
            ticks_to_nmi(TMO + 4, n);
            chk($sformatf("R2 key %0d", k), n, (k == 10) ? 0 : TMO);
        end

        // R5 stop with held count and resume, for every held value
        for (int k = 0; k < TMO; k++) begin
            wr(1'b0, 8'h15);
            ticks_to_nmi(k, n); chk($sformatf("R5 pre k=%0d", k), n, 0);
            wr(1'b0, 8'h0A);
            ticks_to_nmi(6, n); chk($sformatf("R2 hold k=%0d", k), n, 0);
            wr(1'b0, 8'h06);
            ticks_to_nmi(20, n); chk($sformatf("R5 resume k=%0d", k), n, TMO - k);
        end

        // R9 sleep freezes the count
        wr(1'b0, 8'h15);
        ticks_to_nmi(3, n);
        osc_run = 1'b0;
        ticks_to_nmi(10, n); chk("R9 sleep no timeout", n, 0);
        osc_run = 1'b1;
        ticks_to_nmi(20, n); chk("R9 resume after sleep", n, TMO - 3);

        // R3 restart in mid-period gives a full period
        wr(1'b0, 8'h15);
        ticks_to_nmi(6, n);
        wr(1'b0, 8'h15);
        ticks_to_nmi(20, n); chk("R3 mid restart", n, TMO);

        // R8 reset mode
        wr(1'b0, 8'h15);
        wr(1'b1, 8'h02);
        rd(1'b1, v); chk("R8 mode readback", v, 8'h02);
        for (int i = 0; i < TMO - 1; i++) tick(nm, rs);
        tick(nm, rs);
        chk("R8 no nmi pulse", int'(nm), 0);
        hc = rs ? 1 : 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (sys_rst_req) hc++;
            if (nmi_req) hc += 100;
        end
        chk("R8 reset hold length", hc, HOLD);
        rd(1'b1, v); chk("R8 flag stays clear", v, 8'h02);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule